// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a pulse-width-modulated output whose duty cycle has ten bits of resolution. The time base is an 8-bit coarse timer joined below by a 2-bit fine counter. Together they form a 10-bit count that advances once for every clock cycle in which the clock enable is high. A period register bounds the coarse timer. When the coarse timer equals the period value and the fine bits are at their top value, the count returns to zero and a new period begins. A period is therefore 4*(P+1) ticks long.

The duty value is written as an 8-bit upper part and a 2-bit lower part. Writes land in a master copy. That copy moves into a hidden slave register only at a period start, so software can change the duty at any moment without producing a malformed pulse. The output is high while the count is below the latched duty. The period register is not buffered and acts on the next comparison. Clearing the control register stops the time base, empties the slave and forces the output low.

Top module: `pwm10_gen`

## Requirements
- R1: After reset the output is low, and it stays low while the enable bit is clear.
- R2: While enabled, the 10-bit count advances by one on each clock edge at which `clk_en` is high and holds when `clk_en` is low. A period lasts 4*(P+1) ticks, where P is the period register.
- R3: Registers are selected by `wr_addr`: 0 = period, 1 = duty upper 8 bits, 2 = duty lower 2 bits (taken from `wr_data[1:0]`), 3 = control (bit 0 enables). The latched duty D is {upper, lower}. Within a period the output is high exactly while the count is below D, so the output is high for D ticks starting at the period start.
- R4: A duty write takes effect only at the next period start. The pulse in progress keeps the previously latched duty.
- R5: A period register write takes effect at once and can shorten the period in progress.
- R6: A latched duty of zero keeps the output low for the whole period. A latched duty of at least 4*(P+1) keeps it high for the whole period.
- R7: After the enable bit is set, the count starts from zero and the output stays low for the first full period. The first period start loads the duty.
- R8: Writing 0 to the control register drives the output low on the second clock edge after the write, clears the count and the latched duty, and keeps the output low until re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Time base advance enable (one tick per high cycle) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_o | output | 1 | PWM output |

## Verification
The hardest case to reach from the ports is a duty write that arrives partway through a pulse. The check must show that the pulse in progress keeps its old length and that the new length appears only in the following period. The stimulus first locks onto a rising edge of the output, which marks count zero. From there it counts the cycles spent on the two register writes, so it knows the exact count at which sampling resumes. It then compares the high cycles in the rest of that period with the old duty and the high cycles in the next whole period with the new one. The same edge-locked approach is used to shorten the period while a period is running, and to disable the block while the output is high.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    typedef enum logic [1:0] {
        SEL_PERIOD  = 2'd0,
        SEL_DUTY_HI = 2'd1,
        SEL_DUTY_LO = 2'd2,
        SEL_CTRL    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pwm10_regs.sv
module pwm10_regs #(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_addr,
    input  logic [TMR_W-1:0]          wr_data,
    output logic [TMR_W-1:0]          period_o,
    output logic [TMR_W+FINE_W-1:0]   duty_o,
    output logic                      run_o
);
    import pwm10_pkg::*;

    typedef struct packed {
        logic [TMR_W-1:0]  period;
        logic [TMR_W-1:0]  duty_hi;
        logic [FINE_W-1:0] duty_lo;
        logic              en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_PERIOD:  r_d.period  = wr_data;
                SEL_DUTY_HI: r_d.duty_hi = wr_data;
                SEL_DUTY_LO: r_d.duty_lo = wr_data[FINE_W-1:0];
                SEL_CTRL:    r_d.en      = wr_data[0];
                default:     r_d         = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign period_o = r_q.period;
    assign duty_o   = {r_q.duty_hi, r_q.duty_lo};
    assign run_o    = r_q.en;

endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase #(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_i,
    input  logic                      tick_i,
    input  logic [TMR_W-1:0]          period_i,
    output logic [TMR_W+FINE_W-1:0]   cnt_o,
    output logic [TMR_W+FINE_W-1:0]   cnt_next_o,
    output logic                      period_end_o
);
    localparam int DUTY_W = TMR_W + FINE_W;

    logic [DUTY_W-1:0] cnt_d, cnt_q;
    logic              coarse_hit;
    logic              fine_top;

    always_comb begin
        coarse_hit   = (cnt_q[DUTY_W-1:FINE_W] == period_i);
        fine_top     = &cnt_q[FINE_W-1:0];
        period_end_o = run_i && tick_i && coarse_hit && fine_top;
        cnt_d        = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            if (period_end_o) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o      = cnt_q;
    assign cnt_next_o = cnt_d;

    // R2: one step per enabled tick inside a period
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !period_end_o) |=> (cnt_q == DUTY_W'($past(cnt_q) + 1'b1)));

    // R2: no tick, no movement
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> $stable(cnt_q));

    // R8: disabled time base sits at zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwm10_duty_out.sv
module pwm10_duty_out #(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_i,
    input  logic                      tick_i,
    input  logic                      period_end_i,
    input  logic [TMR_W+FINE_W-1:0]   duty_i,
    input  logic [TMR_W+FINE_W-1:0]   cnt_next_i,
    output logic                      out_o
);
    localparam int DUTY_W = TMR_W + FINE_W;

    typedef struct packed {
        logic [DUTY_W-1:0] slave;
        logic              out;
    } dstate_t;

    dstate_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!run_i) begin
            s_d = '0;
        end else if (period_end_i) begin
            s_d.slave = duty_i;
            s_d.out   = (duty_i != '0);
        end else if (tick_i && (cnt_next_i == s_q.slave)) begin
            s_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_o = s_q.out;

    // R4: slave copy only changes at a period start
    a_r4_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !period_end_i) |=> $stable(s_q.slave));

    // R3: output rises only at a period start
    a_r3_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.out) |-> $past(period_end_i));

    // R6: zero duty never raises the output
    a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end_i && (duty_i == '0)) |=> !s_q.out);

    // R8: disabled output is low
    a_r8_out_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !s_q.out);

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    output logic             pwm_o
);
    localparam int DUTY_W = TMR_W + FINE_W;

    logic [TMR_W-1:0]  period;
    logic [DUTY_W-1:0] duty_master;
    logic              run;
    logic [DUTY_W-1:0] cnt;
    logic [DUTY_W-1:0] cnt_next;
    logic              period_end;

    pwm10_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .period_o (period),
        .duty_o   (duty_master),
        .run_o    (run)
    );

    pwm10_timebase #(.TMR_W(TMR_W), .FINE_W(FINE_W)) tb_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .tick_i       (clk_en),
        .period_i     (period),
        .cnt_o        (cnt),
        .cnt_next_o   (cnt_next),
        .period_end_o (period_end)
    );

    pwm10_duty_out #(.TMR_W(TMR_W), .FINE_W(FINE_W)) out_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .tick_i       (clk_en),
        .period_end_i (period_end),
        .duty_i       (duty_master),
        .cnt_next_i   (cnt_next),
        .out_o        (pwm_o)
    );

    // R1: output low while disabled (checked at the top level)
    a_r1_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> !pwm_o);

endmodule

// File: tb/pwm10_gen_tb_top.sv
module pwm10_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pwm_o;

    int checks = 0;
    int errors = 0;
    int en_mode = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        case (en_mode)
            1:       clk_en <= ~clk_en;
            2:       clk_en <= 1'b0;
            default: clk_en <= 1'b1;
        endcase
    end

    pwm10_gen dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_duty(input int d);
        wr(2'd2, 8'(d & 3));
        wr(2'd1, 8'(d >> 2));
    endtask

    task automatic measure(input int n, output int hi, output int first);
        hi = 0;
        first = int'(pwm_o);
        for (int i = 0; i < n; i++) begin
            if (pwm_o) hi++;
            @(negedge clk);
        end
    endtask

    task automatic sync_rise(output int ok);
        logic prev;
        ok = 0;
        prev = pwm_o;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!prev && pwm_o) begin
                ok = 1;
                return;
            end
            prev = pwm_o;
        end
    endtask

    task automatic test_reset();
        int hi, f;
        check_eq("R1", "output in reset", int'(pwm_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        measure(30, hi, f);
        check_eq("R1", "high cycles while not enabled", hi, 0);
    endtask

    task automatic test_first_period();
        int hi, f;
        wr(2'd0, 8'd3);
        set_duty(5);
        wr(2'd3, 8'd1);
        measure(16, hi, f);
        check_eq("R7", "high cycles in first period", hi, 0);
        measure(16, hi, f);
        check_eq("R3", "second period starts high", f, 1);
        check_eq("R3", "high cycles for duty 5", hi, 5);
    endtask

    task automatic test_patterns();
        int hi, f, ok, gap;
        int duties[6] = '{1, 7, 15, 16, 40, 0};
        foreach (duties[k]) begin
            set_duty(duties[k]);
            repeat (40) @(negedge clk);
            measure(32, hi, f);
            if (duties[k] == 0)
                check_eq("R6", "zero duty high cycles", hi, 0);
            else if (duties[k] >= 16)
                check_eq("R6", "full duty high cycles", hi, 32);
            else
                check_eq("R3", $sformatf("duty %0d high cycles", duties[k]), hi, 2 * duties[k]);
        end
        set_duty(7);
        repeat (40) @(negedge clk);
        sync_rise(ok);
        check_eq("R2", "rise found", ok, 1);
        gap = 0;
        begin
            logic prev;
            prev = pwm_o;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                gap++;
                if (!prev && pwm_o) break;
                prev = pwm_o;
            end
        end
        check_eq("R2", "period length for P=3", gap, 16);
    endtask

    task automatic test_deferred();
        int hi, f, ok;
        set_duty(5);
        repeat (40) @(negedge clk);
        sync_rise(ok);
        check_eq("R4", "rise found", ok, 1);
        set_duty(10);
        measure(12, hi, f);
        check_eq("R4", "rest of period keeps old duty", hi, 1);
        measure(16, hi, f);
        check_eq("R4", "next period starts high", f, 1);
        check_eq("R4", "next period uses new duty", hi, 10);
    endtask

    task automatic test_period_live();
        int hi, f, ok, n;
        logic prev;
        set_duty(5);
        repeat (40) @(negedge clk);
        sync_rise(ok);
        wr(2'd0, 8'd1);
        n = 2;
        prev = pwm_o;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n++;
            if (!prev && pwm_o) break;
            prev = pwm_o;
        end
        check_eq("R5", "shortened period length", n, 8);
        measure(16, hi, f);
        check_eq("R5", "high cycles over two short periods", hi, 10);
        wr(2'd0, 8'd3);
        repeat (40) @(negedge clk);
    endtask

    task automatic test_clk_en();
        int hi, f, ok, gap;
        logic prev;
        @(posedge clk); en_mode = 1;
        repeat (80) @(negedge clk);
        sync_rise(ok);
        gap = 0;
        prev = pwm_o;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            gap++;
            if (!prev && pwm_o) break;
            prev = pwm_o;
        end
        check_eq("R2", "period with half-rate ticks", gap, 32);
        @(posedge clk); en_mode = 2;
        @(negedge clk);
        measure(50, hi, f);
        check_eq("R2", "output frozen high without ticks", hi, 50);
        @(posedge clk); en_mode = 0;
        repeat (40) @(negedge clk);
    endtask

    task automatic test_disable();
        int hi, f, ok;
        sync_rise(ok);
        wr(2'd3, 8'd0);
        @(negedge clk);
        check_eq("R8", "output low after disable", int'(pwm_o), 0);
        set_duty(9);
        measure(40, hi, f);
        check_eq("R8", "high cycles while disabled", hi, 0);
        wr(2'd3, 8'd1);
        measure(16, hi, f);
        check_eq("R7", "first period after re-enable low", hi, 0);
        measure(16, hi, f);
        check_eq("R7", "first loaded period starts high", f, 1);
        check_eq("R3", "re-enabled duty 9 high cycles", hi, 9);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_first_period();
        test_patterns();
        test_deferred();
        test_period_live();
        test_clk_en();
        test_disable();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule